// File: doc/BRIEF.md
# String Repeat Sequencer

This block steps a string instruction that carries a repeat prefix through its iterations. It receives the instruction when it issues: the prefix and repeatable attributes, whether the instruction is a compare type, the 2-bit repeat code, the address size, the starting count register value, the current instruction pointer and the instruction length. It then produces one execute strobe per cycle for the execution datapath. Each strobe decrements the count. After each strobe the block decides whether to stop, using the count and, for compare types, the zero flag that the datapath returns for that iteration.

The count is always held as a 64-bit register. The address size decides how many of its low bits act as the counter, and the other bits are left untouched. When an iteration does not end the instruction and an asynchronous event is pending, the block gives up control. It pulses a yield output, which the fetch side uses to drop its prefetch window. It leaves the instruction pointer where it was, so the instruction restarts later with the count it had reached. When the instruction finishes, the block advances the pointer by the instruction length. An instruction without a usable repeat prefix advances the pointer first and then executes exactly once.

Top module: `rep_sequencer`

## Requirements
- R1: An iteration raises `exec_o` and decrements the count only if the active count bits are non-zero. A zero starting count produces no execute strobe, and the instruction completes in the cycle after the issue edge.
- R2: `asz_i` selects the active count bits: 0 selects bits 15:0, 1 selects bits 31:0, and 2 or 3 selects all 64 bits. The bits above the active field never change, and the active field does not borrow from them.
- R3: When `cmp_i` is 1 and `rep_code_i` is 3, the sequence stops after an iteration that returns `zf_i` = 0.
- R4: When `cmp_i` is 1 and `rep_code_i` is 2, the sequence stops after an iteration that returns `zf_i` = 1.
- R5: When `cmp_i` is 0, `zf_i` is ignored and the sequence stops only when the active count reaches zero.
- R6: On completion, `done_o` pulses for one cycle, and in that same cycle `ip_o` equals the issue pointer plus `ilen_i`, modulo 2^64.
- R7: If an iteration does not stop the sequence and `event_i` is high at that clock edge, the block returns to idle. In the next cycle it pulses `yield_o` with `ip_o` equal to the issue pointer and `count_o` holding the count reached so far.
- R8: An instruction issued with `rep_i` or `repable_i` low produces exactly one execute strobe, in the cycle after issue. `ip_o` already shows the advanced pointer during that cycle, and `done_o` follows in the next cycle.
- R9: `busy_o` is high from the cycle after issue until completion or yield. A `start_i` that arrives while busy is ignored.
- R10: After reset, `busy_o`, `exec_o`, `done_o` and `yield_o` are low, and `count_o` and `ip_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Issue strobe, accepted when idle |
| rep_i | input | 1 | Instruction carries a repeat prefix |
| repable_i | input | 1 | Instruction is a repeatable string operation |
| cmp_i | input | 1 | Compare-type string operation (zero flag matters) |
| rep_code_i | input | 2 | Repeat code: 2 stops on ZF=1, 3 stops on ZF=0 |
| asz_i | input | 2 | Address size: 0=16, 1=32, 2/3=64 bits of count |
| count_i | input | 64 | Starting count register value |
| ip_i | input | 64 | Instruction pointer at issue |
| ilen_i | input | 4 | Instruction length in bytes |
| zf_i | input | 1 | Zero flag produced by the current iteration |
| event_i | input | 1 | Asynchronous event pending |
| exec_o | output | 1 | Execute strobe for one iteration |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Instruction completed (one-cycle pulse) |
| yield_o | output | 1 | Yielded to an event; drop the prefetch window |
| count_o | output | 64 | Current count register value |
| ip_o | output | 64 | Committed instruction pointer |

## Verification
The bench drives a zero starting count; a design that executed once anyway would show a strobe and a wrapped counter. It runs a 16-bit count with its upper bits set. A borrow into those bits, or a decrement of the full register, would change bits above 15. It flips the zero flag at a chosen iteration for both compare codes, and flips it during a plain repeat. Swapped codes, or a flag that leaks into the plain variant, would stop at the wrong iteration. It raises an event during a long sequence; a design that advanced the pointer on yield would restart past the instruction. It also covers the non-repeat path, where the pointer must already be advanced while the single strobe is out.

// File: rtl/rep_sequencer.sv
module rep_sequencer #(
  parameter int IP_W  = 64,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rep_i,
  input  logic             repable_i,
  input  logic             cmp_i,
  input  logic [1:0]       rep_code_i,
  input  logic [1:0]       asz_i,
  input  logic [63:0]      count_i,
  input  logic [IP_W-1:0]  ip_i,
  input  logic [LEN_W-1:0] ilen_i,
  input  logic             zf_i,
  input  logic             event_i,
  output logic             exec_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             yield_o,
  output logic [63:0]      count_o,
  output logic [IP_W-1:0]  ip_o
);
  localparam int CW = 64;
  localparam logic [1:0] CODE_NE = 2'd2;
  localparam logic [1:0] CODE_EQ = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_ONE, S_RUN} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [IP_W-1:0]  ip;
  logic [LEN_W-1:0] len;
  logic [1:0]       asz, code;
  logic             cmp, done_q, yld_q;

  logic [CW-1:0] act_cnt, dec_cnt;
  logic          nz, last, zf_stop, stop;
  logic [IP_W-1:0] ip_next;

  always_comb begin
    case (asz)
      2'd0: begin
        act_cnt = {48'd0, cnt[15:0]};
        dec_cnt = {cnt[63:16], cnt[15:0] - 16'd1};
      end
      2'd1: begin
        act_cnt = {32'd0, cnt[31:0]};
        dec_cnt = {cnt[63:32], cnt[31:0] - 32'd1};
      end
      default: begin
        act_cnt = cnt;
        dec_cnt = cnt - 64'd1;
      end
    endcase
  end

  assign nz      = act_cnt != '0;
  assign last    = act_cnt <= 64'd1;
  assign zf_stop = nz && cmp && (((code == CODE_EQ) && !zf_i) || ((code == CODE_NE) && zf_i));
  assign stop    = last || zf_stop;
  assign ip_next = ip + IP_W'(len);

  assign exec_o  = (st == S_ONE) || ((st == S_RUN) && nz);
  assign busy_o  = st != S_IDLE;
  assign done_o  = done_q;
  assign yield_o = yld_q;
  assign count_o = cnt;
  assign ip_o    = ip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ip     <= '0;
      len    <= '0;
      asz    <= '0;
      code   <= '0;
      cmp    <= 1'b0;
      done_q <= 1'b0;
      yld_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      yld_q  <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          cnt  <= count_i;
          len  <= ilen_i;
          asz  <= asz_i;
          code <= rep_code_i;
          cmp  <= cmp_i;
          if (rep_i && repable_i) begin
            ip <= ip_i;
            st <= S_RUN;
          end else begin
            ip <= ip_i + IP_W'(ilen_i);
            st <= S_ONE;
          end
        end
        S_ONE: begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        S_RUN: begin
          if (nz) cnt <= dec_cnt;
          if (stop) begin
            ip     <= ip_next;
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else if (event_i) begin
            st    <= S_IDLE;
            yld_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_EXEC_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && st == S_RUN) |=> (count_o != $past(count_o))); // R1
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && st == S_RUN && asz == 2'd0) |=> (count_o[63:16] == $past(count_o[63:16]))); // R2
  AST_YIELD_IP: assert property (@(posedge clk) disable iff (!rst_n)
    yield_o |-> $stable(ip_o)); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exec_o, done_o, yield_o})); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !exec_o); // R9
endmodule

// File: tb/sim_rep_sequencer.sv
module sim_rep_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, rep_i = 0, repable_i = 0, cmp_i = 0, zf_i = 0, event_i = 0;
  logic [1:0] rep_code_i = 0, asz_i = 0;
  logic [63:0] count_i = 0, ip_i = 0;
  logic [3:0] ilen_i = 0;
  logic exec_o, busy_o, done_o, yield_o;
  logic [63:0] count_o, ip_o;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rep_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rep_i(rep_i), .repable_i(repable_i),
    .cmp_i(cmp_i), .rep_code_i(rep_code_i), .asz_i(asz_i), .count_i(count_i),
    .ip_i(ip_i), .ilen_i(ilen_i), .zf_i(zf_i), .event_i(event_i),
    .exec_o(exec_o), .busy_o(busy_o), .done_o(done_o), .yield_o(yield_o),
    .count_o(count_o), .ip_o(ip_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int  nexec;
  bit  got_done, got_yield;
  logic [63:0] ip_during_exec;

  task automatic run(input bit rep, input bit rpb, input bit cmp, input logic [1:0] code,
                     input logic [1:0] asz, input logic [63:0] cnt, input logic [63:0] ip,
                     input logic [3:0] len, input int hit, input bit zdef, input bit ev);
    nexec = 0; got_done = 0; got_yield = 0;
    @(negedge clk);
    rep_i = rep; repable_i = rpb; cmp_i = cmp; rep_code_i = code; asz_i = asz;
    count_i = cnt; ip_i = ip; ilen_i = len; event_i = ev; zf_i = zdef; start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k < 300; k++) begin
      if (done_o) begin got_done = 1; break; end
      if (yield_o) begin got_yield = 1; break; end
      zf_i = (nexec + 1 == hit) ? ~zdef : zdef;
      if (exec_o) begin nexec++; ip_during_exec = ip_o; end
      @(negedge clk);
    end
    event_i = 0;
  endtask

  task automatic t_reset;
    chk("R10 busy", busy_o, 0);
    chk("R10 exec", exec_o, 0);
    chk("R10 done", done_o, 0);
    chk("R10 yield", yield_o, 0);
    chk("R10 count", count_o, 0);
    chk("R10 ip", ip_o, 0);
  endtask

  task automatic t_plain;
    run(1, 1, 0, 2'd0, 2'd2, 64'd5, 64'h1000, 4'd2, 3, 1'b0, 0);
    chk("R5 exec count ignores zf", nexec, 5);
    chk("R6 done", got_done, 1);
    chk("R6 ip", ip_o, 64'h1002);
    chk("R5 count", count_o, 0);
    chk("R9 idle after done", busy_o, 0);
  endtask

  task automatic t_zero;
    run(1, 1, 1, 2'd3, 2'd1, 64'hABCD_0000_0000_0000, 64'h20, 4'd1, 0, 1'b1, 0);
    chk("R1 zero count no exec", nexec, 0);
    chk("R1 count kept", count_o, 64'hABCD_0000_0000_0000);
    chk("R6 ip zero count", ip_o, 64'h21);
  endtask

  task automatic t_width16;
    run(1, 1, 0, 2'd0, 2'd0, 64'h1234_5678_9ABC_0003, 64'h40, 4'd3, 0, 1'b0, 0);
    chk("R2 16-bit exec", nexec, 3);
    chk("R2 16-bit upper kept", count_o, 64'h1234_5678_9ABC_0000);
    run(1, 1, 0, 2'd0, 2'd1, 64'hFFFF_FFFF_0000_0002, 64'h40, 4'd3, 0, 1'b0, 0);
    chk("R2 32-bit exec", nexec, 2);
    chk("R2 32-bit upper kept", count_o, 64'hFFFF_FFFF_0000_0000);
  endtask

  task automatic t_repe;
    run(1, 1, 1, 2'd3, 2'd2, 64'd10, 64'h100, 4'd2, 4, 1'b1, 0);
    chk("R3 stops on zf0", nexec, 4);
    chk("R3 remaining count", count_o, 6);
    chk("R3 ip", ip_o, 64'h102);
  endtask

  task automatic t_repne;
    run(1, 1, 1, 2'd2, 2'd0, 64'd8, 64'h200, 4'd2, 2, 1'b0, 0);
    chk("R4 stops on zf1", nexec, 2);
    chk("R4 remaining count", count_o, 6);
    run(1, 1, 1, 2'd2, 2'd0, 64'd3, 64'h200, 4'd2, 0, 1'b0, 0);
    chk("R4 runs out", nexec, 3);
  endtask

  task automatic t_yield;
    run(1, 1, 0, 2'd0, 2'd2, 64'd6, 64'hFFFF_FFFF_FFFF_FFFE, 4'd4, 0, 1'b0, 1);
    chk("R7 yield seen", got_yield, 1);
    chk("R7 one exec", nexec, 1);
    chk("R7 ip unchanged", ip_o, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R7 count reached", count_o, 5);
    chk("R7 idle", busy_o, 0);
    run(1, 1, 0, 2'd0, 2'd2, count_o, ip_o, 4'd4, 0, 1'b0, 0);
    chk("R7 resume exec", nexec, 5);
    chk("R6 ip wraps", ip_o, 64'h2);
  endtask

  task automatic t_single;
    run(0, 1, 0, 2'd0, 2'd2, 64'd9, 64'h300, 4'd7, 0, 1'b0, 0);
    chk("R8 one exec", nexec, 1);
    chk("R8 ip advanced during exec", ip_during_exec, 64'h307);
    chk("R8 count untouched", count_o, 9);
    run(1, 0, 0, 2'd0, 2'd2, 64'd0, 64'h400, 4'd3, 0, 1'b0, 0);
    chk("R8 not repeatable exec", nexec, 1);
    chk("R8 ip", ip_o, 64'h403);
  endtask

  task automatic t_busy_start;
    @(negedge clk);
    rep_i = 1; repable_i = 1; cmp_i = 0; asz_i = 2; count_i = 64'd4; ip_i = 64'h500;
    ilen_i = 1; start_i = 1;
    @(negedge clk);
    count_i = 64'd100; ip_i = 64'h900;
    chk("R9 busy", busy_o, 1);
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k < 20; k++) begin
      if (done_o) break;
      @(negedge clk);
    end
    chk("R9 second start ignored ip", ip_o, 64'h501);
    chk("R9 second start ignored count", count_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_plain();
    t_zero();
    t_width16();
    t_repe();
    t_repne();
    t_yield();
    t_single();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule